// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs external memory cycles for a CPU-side requester over a shared 16-bit address/data bus. A request names a byte or word, read or write, and whether it is an instruction fetch. The controller places the address on the bus, drives an address strobe that an external latch uses on its falling edge, and then runs a data phase with read or write strobes. It stretches the data phase while the memory holds its ready input low, and it ends with a one-cycle done pulse that returns read data.

Each cycle runs at 8 or 16 bits, either fixed by configuration or chosen per cycle by a width input. A word access on an 8-bit cycle becomes two byte cycles. The address strobe can act as a short latch pulse or as an address-valid level. The high-byte pin can act as a high-lane enable or as a write strobe for odd bytes. A divided bus clock output is generated, and wait states end only where it rises.

Top module: `xbus_ctrl`

## Requirements
- R1: Latch-pulse mode (`cfg_adv`=0): `as_o` is high for exactly one cycle per bus cycle. In that cycle `ad_o` carries the byte address and `ad_oe` is 1.
- R2: Address-valid mode (`cfg_adv`=1): `as_o` is high while idle. It falls in the address phase and stays low through the data and wait phases. It is high again in the completion cycle, so each byte cycle of a split access has its own falling edge.
- R3: While idle (`req_ready`=1), `rd_n`, `wr_n` and `hb_n` are 1 and `done` is 0. In latch-pulse mode `as_o` is 0 while idle.
- R4: `rd_n` is low only in the data and wait phases of read cycles. `wr_n` is low only in the data and wait phases of write cycles, and `ad_oe` is 1 whenever `wr_n` is low.
- R5: High-lane mode (`cfg_wrh`=0): `hb_n` is low during a write data phase only when a 16-bit cycle writes the high lane `ad_o[15:8]` (a word, or a byte at an odd address). It stays high on reads and on 8-bit cycles.
- R6: Odd-write mode (`cfg_wrh`=1): `hb_n` is low during a write data phase only when the byte written has an odd address. On an 8-bit split word write this is the second byte cycle only.
- R7: Width code `cfg_width`: 2'b00 gives 8-bit cycles, and 2'b01 or 2'b10 give 16-bit cycles. With 2'b11, `bw_i` is sampled in the address phase: 0 gives an 8-bit cycle and 1 gives a 16-bit cycle.
- R8: A word access ignores address bit 0. On an 8-bit cycle it becomes two byte cycles: the even address first, carrying the low byte on `ad[7:0]`, then the odd address, carrying the high byte on `ad[7:0]`. The whole access completes 6 cycles after acceptance.
- R9: A data phase that samples `rdy_i`=1 completes on the next edge. Otherwise wait cycles follow until an edge where `rdy_i`=1 and `clk_out` rises, so `clk_out` is 1 in the completion cycle after any wait.
- R10: `inst_o` is 1 from the address phase through the done cycle of a fetch request, and 0 otherwise.
- R11: `done` is a one-cycle pulse. A 16-bit no-wait access finishes in the third cycle after acceptance. `rdata` is valid with `done`. Byte reads are zero-extended, and on a 16-bit cycle an odd byte is taken from `ad_i[15:8]`.
- R12: `req_ready` is 1 only while idle. A request is taken on an edge where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Request is an instruction fetch |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| done | output | 1 | Access complete pulse |
| rdata | output | 16 | Read data |
| cfg_adv | input | 1 | Address strobe style: 1 = address-valid level |
| cfg_wrh | input | 1 | High-byte pin style: 1 = odd-byte write strobe |
| cfg_width | input | 2 | Bus width code |
| bw_i | input | 1 | Dynamic width select |
| rdy_i | input | 1 | Memory ready |
| ad_o | output | 16 | Multiplexed bus, driven value |
| ad_i | input | 16 | Multiplexed bus, sampled value |
| ad_oe | output | 1 | Bus output enable |
| as_o | output | 1 | Address strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| hb_n | output | 1 | High-byte enable or odd-byte write strobe |
| inst_o | output | 1 | Fetch-cycle indicator |
| clk_out | output | 1 | Bus clock, half the input rate |

## Verification
The hardest case to reach from the ports is a wait state whose release lands on the wrong half of the bus clock. In that case ready rises while `clk_out` is high, and the controller must hold one further cycle. The stimulus holds ready low into the wait phase and then raises it in two runs whose release cycles differ by one. This covers both phases of `clk_out`, and each run's completion cycle is predicted from the `clk_out` value seen when ready rose. Odd-byte strobing on the second half of a split write needs the width forced to 8 bits, so word writes are also run with width fixed at 8 bits and with width chosen per cycle by `bw_i`.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      XB_IDLE,
      XB_ADDR,
      XB_DATA,
      XB_WAIT,
      XB_END
   } xb_state_e;

   localparam logic [1:0] XB_W8   = 2'b00;
   localparam logic [1:0] XB_WDYN = 2'b11;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter bit EDGE_RELEASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_fetch,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        cfg_width,
   input  logic              bw_i,
   input  logic              rdy_i,
   output xb_state_e         st,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              lat_write,
   output logic              lat_fetch,
   output logic              lat_word,
   output logic              wide,
   output logic              part,
   output logic              last,
   output logic              clk_out
);
   logic [ADDR_W-1:0] base;
   logic release_w;
   logic wide_now;
   logic split;

   generate
      if (EDGE_RELEASE) begin : g_edge
         assign release_w = rdy_i & ~clk_out;
      end else begin : g_any
         assign release_w = rdy_i;
      end
   endgenerate

   assign wide_now = (cfg_width == XB_WDYN) ? bw_i : (cfg_width != XB_W8);
   assign split    = lat_word & ~wide;
   assign last     = ~(split & ~part);
   assign cur_addr = {base[ADDR_W-1:1], base[0] | part};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= XB_IDLE;
         base      <= '0;
         lat_write <= 1'b0;
         lat_fetch <= 1'b0;
         lat_word  <= 1'b0;
         wide      <= 1'b1;
         part      <= 1'b0;
         clk_out   <= 1'b0;
      end else begin
         clk_out <= ~clk_out;
         case (st)
            XB_IDLE: if (req_valid) begin
               base      <= req_word ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
               lat_write <= req_write;
               lat_fetch <= req_fetch;
               lat_word  <= req_word;
               part      <= 1'b0;
               st        <= XB_ADDR;
            end
            XB_ADDR: begin
               if (!part) wide <= wide_now;
               st <= XB_DATA;
            end
            XB_DATA: st <= rdy_i ? XB_END : XB_WAIT;
            XB_WAIT: if (release_w) st <= XB_END;
            XB_END: begin
               if (!last) begin
                  part <= 1'b1;
                  st   <= XB_ADDR;
               end else begin
                  st <= XB_IDLE;
               end
            end
            default: st <= XB_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
   import xbus_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BYTE_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  xb_state_e         st,
   input  logic              wide,
   input  logic              part,
   input  logic              lat_word,
   input  logic              lat_write,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] ad_i,
   output logic [DATA_W-1:0] ad_o,
   output logic              ad_oe,
   output logic [DATA_W-1:0] rdata
);
   localparam int HI_W = DATA_W - BYTE_W;

   logic [BYTE_W-1:0] w_lo, w_hi, r_lo, r_hi, lo_src;
   logic data_ph;

   assign w_lo    = wdata[BYTE_W-1:0];
   assign w_hi    = wdata[DATA_W-1:BYTE_W];
   assign r_lo    = ad_i[BYTE_W-1:0];
   assign r_hi    = ad_i[DATA_W-1:BYTE_W];
   assign data_ph = (st == XB_DATA) || (st == XB_WAIT);
   assign lo_src  = (wide && !lat_word && cur_addr[0]) ? r_hi : r_lo;

   always_comb begin
      ad_o = '0;
      if (st == XB_ADDR)     ad_o = DATA_W'(cur_addr);
      else if (wide)         ad_o = lat_word ? wdata : {w_lo, w_lo};
      else                   ad_o[BYTE_W-1:0] = part ? w_hi : w_lo;
   end

   assign ad_oe = (st == XB_ADDR) || (lat_write && (data_ph || st == XB_END));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (data_ph && !lat_write) begin
         if (wide && lat_word)     rdata <= ad_i;
         else if (!wide && part)   rdata[DATA_W-1:BYTE_W] <= r_lo;
         else                      rdata <= {{HI_W{1'b0}}, lo_src};
      end
   end
endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe
   import xbus_pkg::*;
(
   input  xb_state_e st,
   input  logic      lat_write,
   input  logic      lat_fetch,
   input  logic      lat_word,
   input  logic      wide,
   input  logic      cur_a0,
   input  logic      cfg_adv,
   input  logic      cfg_wrh,
   output logic      as_o,
   output logic      rd_n,
   output logic      wr_n,
   output logic      hb_n,
   output logic      inst_o
);
   logic data_ph, hi_lane, odd_byte;

   assign data_ph  = (st == XB_DATA) || (st == XB_WAIT);
   assign hi_lane  = wide & (lat_word | cur_a0);
   assign odd_byte = wide ? (lat_word | cur_a0) : cur_a0;

   assign as_o   = cfg_adv ? ~((st == XB_ADDR) || data_ph) : (st == XB_ADDR);
   assign rd_n   = ~(data_ph & ~lat_write);
   assign wr_n   = ~(data_ph & lat_write);
   assign hb_n   = ~(data_ph & lat_write & (cfg_wrh ? odd_byte : hi_lane));
   assign inst_o = lat_fetch & (st != XB_IDLE);
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
   import xbus_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int BYTE_W       = 8,
   parameter int DATA_W       = 16,
   parameter bit EDGE_RELEASE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_fetch,
   input  logic              req_word,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   input  logic              cfg_adv,
   input  logic              cfg_wrh,
   input  logic [1:0]        cfg_width,
   input  logic              bw_i,
   input  logic              rdy_i,
   output logic [DATA_W-1:0] ad_o,
   input  logic [DATA_W-1:0] ad_i,
   output logic              ad_oe,
   output logic              as_o,
   output logic              rd_n,
   output logic              wr_n,
   output logic              hb_n,
   output logic              inst_o,
   output logic              clk_out
);
   generate
      if (DATA_W != 2 * BYTE_W) begin : g_bad_lanes
         $error("xbus_ctrl: DATA_W must hold exactly two byte lanes");
      end
      if (ADDR_W > DATA_W || ADDR_W < 2) begin : g_bad_addr
         $error("xbus_ctrl: ADDR_W must fit the multiplexed bus");
      end
   endgenerate

   xb_state_e         st;
   logic [ADDR_W-1:0] cur_addr;
   logic lat_write, lat_fetch, lat_word, wide, part, last;

   xbus_seq #(.ADDR_W(ADDR_W), .EDGE_RELEASE(EDGE_RELEASE)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_fetch(req_fetch), .req_word(req_word), .req_addr(req_addr),
      .cfg_width(cfg_width), .bw_i(bw_i), .rdy_i(rdy_i), .st(st),
      .cur_addr(cur_addr), .lat_write(lat_write), .lat_fetch(lat_fetch),
      .lat_word(lat_word), .wide(wide), .part(part), .last(last),
      .clk_out(clk_out)
   );

   xbus_lane #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DATA_W(DATA_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .st(st), .wide(wide), .part(part),
      .lat_word(lat_word), .lat_write(lat_write), .cur_addr(cur_addr),
      .wdata(req_wdata), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
      .rdata(rdata)
   );

   xbus_strobe u_strobe (
      .st(st), .lat_write(lat_write), .lat_fetch(lat_fetch),
      .lat_word(lat_word), .wide(wide), .cur_a0(cur_addr[0]),
      .cfg_adv(cfg_adv), .cfg_wrh(cfg_wrh), .as_o(as_o), .rd_n(rd_n),
      .wr_n(wr_n), .hb_n(hb_n), .inst_o(inst_o)
   );

   assign req_ready = (st == XB_IDLE);
   assign done      = (st == XB_END) && last;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic req_ready,
   input logic done,
   input logic cfg_adv,
   input logic rdy_i,
   input logic ad_oe,
   input logic as_o,
   input logic rd_n,
   input logic wr_n,
   input logic hb_n,
   input logic inst_o
);
   AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_adv && as_o) |=> !as_o); // R1
   AST_ALE_ADDR_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_adv && as_o) |-> ad_oe); // R1
   AST_ADV_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_adv && req_ready) |-> as_o); // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (rd_n && wr_n && hb_n && !done)); // R3
   AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n)); // R4
   AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |-> ad_oe); // R4
   AST_HB_NOT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> hb_n); // R5
   AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !rdy_i) |=> !rd_n); // R9
   AST_INST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !inst_o); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !req_ready); // R12
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
   .cfg_adv(cfg_adv), .rdy_i(rdy_i), .ad_oe(ad_oe), .as_o(as_o),
   .rd_n(rd_n), .wr_n(wr_n), .hb_n(hb_n), .inst_o(inst_o)
);

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_word = 1'b0;
   logic [15:0] req_addr = '0, req_wdata = '0;
   logic cfg_adv = 1'b0, cfg_wrh = 1'b0, bw_i = 1'b0, rdy_i = 1'b1;
   logic [1:0] cfg_width = 2'b01;
   logic req_ready, done, ad_oe, as_o, rd_n, wr_n, hb_n, inst_o, clk_out;
   logic [15:0] rdata, ad_o, ad_i;

   logic [7:0] mem [256];
   logic [15:0] lat = '0;
   logic bus8 = 1'b0;
   logic prev_as = 1'b0;
   int n_as, rd_cnt, hb_cnt, hb_part, inst_cnt, asl_cnt;
   logic [15:0] alog [4];
   int n_chk = 0, n_fail = 0;
   int ncyc;
   logic [15:0] got;
   logic ck;
   logic busy_ready;

   always #10 clk = ~clk;

   xbus_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_fetch(req_fetch), .req_word(req_word),
      .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
      .cfg_adv(cfg_adv), .cfg_wrh(cfg_wrh), .cfg_width(cfg_width), .bw_i(bw_i),
      .rdy_i(rdy_i), .ad_o(ad_o), .ad_i(ad_i), .ad_oe(ad_oe), .as_o(as_o),
      .rd_n(rd_n), .wr_n(wr_n), .hb_n(hb_n), .inst_o(inst_o), .clk_out(clk_out)
   );

   assign ad_i = bus8 ? {8'h00, mem[lat[7:0]]}
                      : {mem[{lat[7:1], 1'b1}], mem[{lat[7:1], 1'b0}]};

   // external latch and memory model
   always @(negedge clk) begin
      if (cfg_adv ? (prev_as && !as_o) : as_o) begin
         lat = ad_o;
         if (n_as < 4) alog[n_as] = ad_o;
         n_as++;
      end
      prev_as = as_o;
      if (!rd_n) rd_cnt++;
      if (!as_o) asl_cnt++;
      if (inst_o) inst_cnt++;
      if (!hb_n) begin hb_cnt++; hb_part = n_as; end
      if (!wr_n) begin
         if (bus8) mem[lat[7:0]] = ad_o[7:0];
         else begin
            if (!lat[0]) mem[{lat[7:1], 1'b0}] = ad_o[7:0];
            if (!hb_n)   mem[{lat[7:1], 1'b1}] = ad_o[15:8];
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic wr, input logic fe, input logic wd,
                       input logic [15:0] a, input logic [15:0] wdat, input int hold);
      @(negedge clk);
      n_as = 0; rd_cnt = 0; hb_cnt = 0; hb_part = 0; inst_cnt = 0; asl_cnt = 0;
      busy_ready = 1'b0; ck = 1'b0;
      req_write = wr; req_fetch = fe; req_word = wd; req_addr = a; req_wdata = wdat;
      rdy_i = (hold == 0);
      req_valid = 1'b1;
      @(posedge clk);
      ncyc = 0;
      got = '0;
      forever begin
         @(negedge clk);
         req_valid = 1'b0;
         #1;
         ncyc++;
         if (hold > 0 && ncyc == hold) begin ck = clk_out; rdy_i = 1'b1; end
         if (req_ready) busy_ready = 1'b1;
         if (done) begin got = rdata; break; end
         if (ncyc > 60) break;
      end
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      check(req_ready == 1'b1, "R12 idle ready", req_ready, 1);
      check(rd_n && wr_n && hb_n, "R3 idle strobes", {rd_n, wr_n, hb_n}, 7);
      check(as_o == 1'b0 && done == 1'b0, "R3 idle as/done", {as_o, done}, 0);
      check(inst_o == 1'b0, "R10 idle inst", inst_o, 0);
   endtask

   task automatic t_word16;
      cfg_width = 2'b01; bus8 = 1'b0; cfg_adv = 1'b0;
      xfer(1'b0, 1'b0, 1'b1, 16'h0010, 16'h0, 0);
      check(got == {mem[8'h11], mem[8'h10]}, "R11 word read data", got, {mem[8'h11], mem[8'h10]});
      check(ncyc == 3, "R11 latency", ncyc, 3);
      check(n_as == 1 && alog[0] == 16'h0010, "R1 address pulse", alog[0], 16'h0010);
      check(rd_cnt == 1, "R4 read strobe width", rd_cnt, 1);
      check(busy_ready == 1'b0, "R12 busy not ready", busy_ready, 0);
      @(negedge clk); #1;
      check(done == 1'b0, "R11 done pulse", done, 0);
   endtask

   task automatic t_byte16;
      logic [7:0] keep;
      cfg_width = 2'b01; bus8 = 1'b0; cfg_wrh = 1'b0;
      xfer(1'b0, 1'b0, 1'b0, 16'h0021, 16'h0, 0);
      check(got == {8'h00, mem[8'h21]}, "R11 odd byte lane", got, {8'h00, mem[8'h21]});
      keep = mem[8'h30];
      xfer(1'b1, 1'b0, 1'b0, 16'h0031, 16'h00A5, 0);
      check(mem[8'h31] == 8'hA5 && mem[8'h30] == keep, "R5 odd byte write", mem[8'h31], 8'hA5);
      check(hb_cnt == 1, "R5 high lane strobe", hb_cnt, 1);
      keep = mem[8'h41];
      xfer(1'b1, 1'b0, 1'b0, 16'h0040, 16'h005A, 0);
      check(mem[8'h40] == 8'h5A && mem[8'h41] == keep, "R5 even byte write", mem[8'h40], 8'h5A);
      check(hb_cnt == 0, "R5 no high lane strobe", hb_cnt, 0);
      xfer(1'b1, 1'b0, 1'b1, 16'h0044, 16'hBEEF, 0);
      check({mem[8'h45], mem[8'h44]} == 16'hBEEF, "R5 word write", {mem[8'h45], mem[8'h44]}, 16'hBEEF);
   endtask

   task automatic t_split8;
      cfg_width = 2'b00; bus8 = 1'b1; cfg_wrh = 1'b0;
      xfer(1'b0, 1'b0, 1'b1, 16'h0051, 16'h0, 0);
      check(n_as == 2 && alog[0] == 16'h0050 && alog[1] == 16'h0051, "R8 two addresses", alog[1], 16'h0051);
      check(got == {mem[8'h51], mem[8'h50]}, "R8 assembled read", got, {mem[8'h51], mem[8'h50]});
      check(ncyc == 6, "R8 split latency", ncyc, 6);
      cfg_wrh = 1'b1;
      xfer(1'b1, 1'b0, 1'b1, 16'h0060, 16'hC3D2, 0);
      check({mem[8'h61], mem[8'h60]} == 16'hC3D2, "R8 split write", {mem[8'h61], mem[8'h60]}, 16'hC3D2);
      check(hb_cnt == 1 && hb_part == 2, "R6 odd strobe second byte", hb_part, 2);
      cfg_wrh = 1'b0;
      xfer(1'b1, 1'b0, 1'b0, 16'h0063, 16'h0077, 0);
      check(mem[8'h63] == 8'h77 && hb_cnt == 0, "R5 no high lane on 8-bit", hb_cnt, 0);
   endtask

   task automatic t_dyn;
      cfg_width = 2'b11; bw_i = 1'b0; bus8 = 1'b1;
      xfer(1'b0, 1'b0, 1'b1, 16'h0070, 16'h0, 0);
      check(n_as == 2 && got == {mem[8'h71], mem[8'h70]}, "R7 pin selects 8-bit", n_as, 2);
      bw_i = 1'b1; bus8 = 1'b0;
      xfer(1'b0, 1'b0, 1'b1, 16'h0070, 16'h0, 0);
      check(n_as == 1 && got == {mem[8'h71], mem[8'h70]}, "R7 pin selects 16-bit", n_as, 1);
      cfg_width = 2'b10; bw_i = 1'b0;
      xfer(1'b0, 1'b0, 1'b1, 16'h0072, 16'h0, 0);
      check(n_as == 1, "R7 fixed 16-bit ignores pin", n_as, 1);
   endtask

   task automatic t_adv;
      cfg_adv = 1'b1; cfg_width = 2'b01; bus8 = 1'b0;
      @(negedge clk); #1;
      check(as_o == 1'b1, "R2 idle high", as_o, 1);
      xfer(1'b0, 1'b0, 1'b1, 16'h0080, 16'h0, 0);
      check(asl_cnt == 2 && as_o == 1'b1, "R2 valid window", asl_cnt, 2);
      check(got == {mem[8'h81], mem[8'h80]}, "R2 latched address", got, {mem[8'h81], mem[8'h80]});
      cfg_width = 2'b00; bus8 = 1'b1;
      xfer(1'b0, 1'b0, 1'b1, 16'h0082, 16'h0, 0);
      check(n_as == 2 && asl_cnt == 4, "R2 split falling edges", n_as, 2);
      cfg_adv = 1'b0;
   endtask

   task automatic t_wait;
      cfg_width = 2'b01; bus8 = 1'b0;
      for (int h = 4; h <= 5; h++) begin
         xfer(1'b0, 1'b0, 1'b0, 16'h0090, 16'h0, h);
         check(ncyc == h + 1 + int'(ck), "R9 release on clock rise", ncyc, h + 1 + int'(ck));
         check(clk_out == 1'b1, "R9 clock high at completion", clk_out, 1);
         check(rd_cnt == ncyc - 2, "R9 strobe held", rd_cnt, ncyc - 2);
         check(got == {8'h00, mem[8'h90]}, "R9 data after wait", got, {8'h00, mem[8'h90]});
      end
      rdy_i = 1'b1;
   endtask

   task automatic t_fetch;
      cfg_width = 2'b01; bus8 = 1'b0;
      xfer(1'b0, 1'b1, 1'b1, 16'h00A0, 16'h0, 0);
      check(inst_cnt == 3, "R10 fetch indicator span", inst_cnt, 3);
      @(negedge clk); #1;
      check(inst_o == 1'b0, "R10 indicator drops", inst_o, 0);
      xfer(1'b0, 1'b0, 1'b1, 16'h00A0, 16'h0, 0);
      check(inst_cnt == 0, "R10 no indicator on data read", inst_cnt, 0);
   endtask

   initial begin
      #(20 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
      n_as = 0; rd_cnt = 0; hb_cnt = 0; hb_part = 0; inst_cnt = 0; asl_cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_word16();
      t_byte16();
      t_split8();
      t_dyn();
      t_adv();
      t_wait();
      t_fetch();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule